// File: doc/BRIEF.md
# Host-Side Memory Access Port

This block is the slave end of a host access port. It lets an external host read and write a processor's internal memories over one shared 16-bit data bus. Data memory holds 16-bit words. Program memory holds 24-bit words, and each one moves as two consecutive 16-bit transfers. The host controls the port with these inputs:

- an active-low select strobe;
- an active-low read strobe;
- an active-low write strobe;
- an active-high address-latch strobe.

The port answers on an active-low acknowledge line. All host strobes pass through a synchronizer into the core clock before any decision is taken.

An address-latch cycle loads a start address and a memory-type flag into a control register. The core can also write this register. Every later transfer works at the current address and then advances it: once per transfer in data memory, and once per pair of transfers in program memory. The block requests the internal memory only while the core signals an instruction-cycle boundary, and holds each request for one cycle.

The bus output always shows the word fetched last. A slow host waits for acknowledge (long read). A fast host samples the bus as soon as it strobes (short read), which gives it the word fetched by the previous access while the next word is fetched.

Top module: `hdp_port`

## Requirements
- R1: An address-latch cycle (address-latch strobe high, select low, read and write high) loads bus bits 13:0 as the address and bus bit 14 as the memory type (1 = program, 0 = data). Both values then appear on `ctl_addr_o` and `ctl_pm_o`.
- R2: A pulse on `core_ctl_we` loads `core_ctl_wdata[13:0]` as the address and bit 14 as the memory type.
- R3: In data-memory mode each read returns the 16-bit word at the current address. Each read or write then advances the address by one.
- R4: In program-memory mode a word moves as two transfers. The first transfer carries word bits 23:8. The second carries bits 7:0 in its low byte, with the high byte read as zero. The address advances by one after the second transfer only.
- R5: While select and read are low, `hbus_oe` is high. During a fetch `hack_n` goes high. It returns low with the fetched word on `hbus_out`.
- R6: With the boundary input held high, a first-half or data-memory read completes within 5 core cycles of the strobe. A second-half program-memory read completes exactly one cycle sooner than a first-half read.
- R7: `mem_req` is asserted only while `cyc_bnd` is high and never for two cycles in a row. While `cyc_bnd` stays low, a pending read keeps `hack_n` high.
- R8: The second half of a program-memory read makes no memory request.
- R9: An address latch or a core control write between the two halves of a program-memory read discards the pending half. The next read then fetches the first half at the new address.
- R10: On a read, `hbus_out` presents the previously fetched word as soon as the strobes are asserted. The addressed word is fetched in the background, so the first read of a short-read sequence is a dummy.
- R11: A data-memory write issues one memory write per transfer. A program-memory write issues a single 24-bit write only after the second half, and the high byte of that second transfer is ignored.
- R12: After reset `hack_n` is low, the address is 0, data memory is selected and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel_n | input | 1 | Host select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| hale | input | 1 | Host address-latch strobe, active high |
| hbus_in | input | 16 | Host bus, incoming value |
| hbus_out | output | 16 | Host bus, value driven by the port |
| hbus_oe | output | 1 | Bus output enable during a host read |
| hack_n | output | 1 | Acknowledge, low when the port is ready |
| cyc_bnd | input | 1 | Instruction-cycle boundary grant from the core |
| core_ctl_we | input | 1 | Core write strobe for the control register |
| core_ctl_wdata | input | 15 | Core control value: memory type in bit 14, address in bits 13:0 |
| ctl_addr_o | output | 14 | Current transfer address |
| ctl_pm_o | output | 1 | Current memory type, 1 = program memory |
| mem_req | output | 1 | Internal memory access, one cycle |
| mem_we | output | 1 | Access is a write |
| mem_pm | output | 1 | Access targets program memory |
| mem_addr | output | 14 | Access address |
| mem_wdata | output | 24 | Write data; data memory uses bits 15:0 |
| mem_rdata | input | 24 | Read data, valid the cycle after a read request |

## Verification
The embedded properties are checked on every cycle:

- memory requests happen only on a granted boundary and last one cycle;
- acknowledge is inactive during any memory access;
- no memory read is ever issued for a pending second half;
- the address only ever steps by one, except right after a latch or a core write.

Only the bench scenarios can show the rest:

- which data appears in which half of a program word;
- that a re-latch drops the second half;
- that the high byte of a second write half is ignored;
- that short reads return the previous word;
- the one-cycle saving of a second-half read.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CAPT = 2'd2,
        ST_HOLD = 2'd3
    } hdp_state_e;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } hdp_op_e;

endpackage

// File: rtl/hdp_sync.sv
module hdp_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/hdp_cmd_decode.sv
module hdp_cmd_decode (
    input  logic sel_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic ale,
    output logic rd_act,
    output logic wr_act,
    output logic al_act,
    output logic any_act
);

    always_comb begin
        al_act  = ale && !sel_n && rd_n && wr_n;
        rd_act  = !ale && !sel_n && !rd_n;
        wr_act  = !ale && !sel_n && !wr_n && rd_n;
        any_act = al_act || rd_act || wr_act;
    end

endmodule

// File: rtl/hdp_port.sv
module hdp_port #(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsel_n,
    input  logic                hrd_n,
    input  logic                hwr_n,
    input  logic                hale,
    input  logic [DATA_W-1:0]   hbus_in,
    output logic [DATA_W-1:0]   hbus_out,
    output logic                hbus_oe,
    output logic                hack_n,
    input  logic                cyc_bnd,
    input  logic                core_ctl_we,
    input  logic [ADDR_W:0]     core_ctl_wdata,
    output logic [ADDR_W-1:0]   ctl_addr_o,
    output logic                ctl_pm_o,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_pm,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W+7:0]   mem_wdata,
    input  logic [DATA_W+7:0]   mem_rdata
);
    import hdp_pkg::*;

    localparam int LO_W  = 8;
    localparam int PM_W  = DATA_W + LO_W;
    localparam int PAD_W = DATA_W - LO_W;

    typedef struct packed {
        hdp_state_e          state;
        hdp_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic                pm;
        logic                half;
        logic                taken;
        logic [DATA_W-1:0]   outw;
        logic [LO_W-1:0]     lo;
        logic [DATA_W-1:0]   hi;
        logic [PM_W-1:0]     wdata;
    } regs_t;

    regs_t q, n;

    // synchronized host strobes: {sel_n, rd_n, wr_n, ale}
    logic [3:0] pins_s;
    logic       rd_act, wr_act, al_act, any_act;
    logic       accept;
    logic       latch_acc;

    hdp_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hsel_n, hrd_n, hwr_n, hale}),
        .dout  (pins_s)
    );

    hdp_cmd_decode u_dec (
        .sel_n   (pins_s[3]),
        .rd_n    (pins_s[2]),
        .wr_n    (pins_s[1]),
        .ale     (pins_s[0]),
        .rd_act  (rd_act),
        .wr_act  (wr_act),
        .al_act  (al_act),
        .any_act (any_act)
    );

    always_comb begin
        n         = q;
        latch_acc = 1'b0;
        accept    = (q.state == ST_IDLE) && !q.taken && any_act;

        if (!any_act) n.taken = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    n.taken = 1'b1;
                    if (al_act) begin
                        latch_acc = 1'b1;
                        n.addr    = hbus_in[ADDR_W-1:0];
                        n.pm      = hbus_in[ADDR_W];
                        n.half    = 1'b0;
                    end else if (rd_act) begin
                        n.op    = OP_RD;
                        n.state = (q.pm && q.half) ? ST_HOLD : ST_WAIT;
                    end else begin
                        n.op = OP_WR;
                        if (q.pm && !q.half) begin
                            n.hi    = hbus_in;
                            n.half  = 1'b1;
                            n.state = ST_HOLD;
                        end else begin
                            n.wdata = q.pm ? {q.hi, hbus_in[LO_W-1:0]}
                                           : {{LO_W{1'b0}}, hbus_in};
                            n.state = ST_WAIT;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (cyc_bnd) begin
                    if (q.op == OP_WR) begin
                        n.addr  = q.addr + 1'b1;
                        n.half  = 1'b0;
                        n.state = ST_IDLE;
                    end else begin
                        n.state = ST_CAPT;
                    end
                end
            end
            ST_CAPT: begin
                if (q.pm) begin
                    n.outw = mem_rdata[PM_W-1:LO_W];
                    n.lo   = mem_rdata[LO_W-1:0];
                    n.half = 1'b1;
                end else begin
                    n.outw = mem_rdata[DATA_W-1:0];
                    n.addr = q.addr + 1'b1;
                end
                n.state = ST_IDLE;
            end
            ST_HOLD: begin
                if (q.op == OP_RD) begin
                    n.outw = {{PAD_W{1'b0}}, q.lo};
                    n.half = 1'b0;
                    n.addr = q.addr + 1'b1;
                end
                n.state = ST_IDLE;
            end
            default: n.state = ST_IDLE;
        endcase

        if (core_ctl_we) begin
            n.addr = core_ctl_wdata[ADDR_W-1:0];
            n.pm   = core_ctl_wdata[ADDR_W];
            n.half = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, op: OP_RD, default: '0};
        end else begin
            q <= n;
        end
    end

    assign hbus_out   = q.outw;
    assign hbus_oe    = !hsel_n && !hrd_n;
    assign hack_n     = (q.state != ST_IDLE);
    assign ctl_addr_o = q.addr;
    assign ctl_pm_o   = q.pm;
    assign mem_req    = (q.state == ST_WAIT) && cyc_bnd;
    assign mem_we     = (q.op == OP_WR);
    assign mem_pm     = q.pm;
    assign mem_addr   = q.addr;
    assign mem_wdata  = q.wdata;

    // R7
    req_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cyc_bnd);

    // R7
    single_steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R5
    ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> hack_n);

    // R8
    no_second_half_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_pm) |-> !q.half);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.addr != $past(q.addr)) && !$past(latch_acc) && !$past(core_ctl_we))
        |-> (q.addr == ADDR_W'($past(q.addr) + 1'b1)));

endmodule

// File: tb/sim_hdp_port.sv
`timescale 1ns/1ps
module sim_hdp_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1, hale = 1'b0;
    logic [15:0] hbus_in = '0;
    logic [15:0] hbus_out;
    logic        hbus_oe, hack_n;
    logic        cyc_bnd = 1'b1;
    logic        core_ctl_we = 1'b0;
    logic [14:0] core_ctl_wdata = '0;
    logic [13:0] ctl_addr_o;
    logic        ctl_pm_o;
    logic        mem_req, mem_we, mem_pm;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;

    int vectors = 0;
    int misses  = 0;
    int nreq    = 0;
    int bnd_mode = 0;
    int tick = 0;
    bit ended = 0;

    logic [15:0] dmm [64];
    logic [23:0] pmm [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdp_port u0 (
        .clk(clk), .rst_n(rst_n), .hsel_n(hsel_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
        .hale(hale), .hbus_in(hbus_in), .hbus_out(hbus_out), .hbus_oe(hbus_oe),
        .hack_n(hack_n), .cyc_bnd(cyc_bnd), .core_ctl_we(core_ctl_we),
        .core_ctl_wdata(core_ctl_wdata), .ctl_addr_o(ctl_addr_o), .ctl_pm_o(ctl_pm_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_pm(mem_pm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] dm_init(input int i);
        return 16'h1000 + 16'(i) * 16'h0101;
    endfunction

    function automatic logic [23:0] pm_init(input int i);
        return 24'h800000 + 24'(i) * 24'h010203;
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            dmm[i] = dm_init(i);
            pmm[i] = pm_init(i);
        end
    end

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            nreq <= nreq + 1;
            if (mem_we) begin
                if (mem_pm) pmm[mem_addr[5:0]] <= mem_wdata;
                else        dmm[mem_addr[5:0]] <= mem_wdata[15:0];
            end else begin
                mem_rdata <= mem_pm ? pmm[mem_addr[5:0]] : {8'h00, dmm[mem_addr[5:0]]};
            end
        end
    end

    always @(negedge clk) begin
        tick <= tick + 1;
        case (bnd_mode)
            0: cyc_bnd <= 1'b1;
            1: cyc_bnd <= (tick % 3 == 0);
            default: cyc_bnd <= 1'b0;
        endcase
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    task automatic do_latch(input logic pm, input int a);
        @(negedge clk);
        hbus_in = {1'b0, pm, 14'(a)};
        hale = 1'b1; hsel_n = 1'b0;
        repeat (4) @(negedge clk);
        hale = 1'b0; hsel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(output logic [15:0] d, output int lat,
                           output logic [15:0] early, output logic oe);
        bit seen;
        @(negedge clk);
        hsel_n = 1'b0; hrd_n = 1'b0;
        #1 early = hbus_out;
        lat = 0; seen = 0;
        while (lat < 2000) begin
            @(negedge clk);
            lat++;
            if (hack_n) seen = 1;
            else if (seen) break;
        end
        d = hbus_out; oe = hbus_oe;
        hsel_n = 1'b1; hrd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic short_read(output logic [15:0] early);
        @(negedge clk);
        hsel_n = 1'b0; hrd_n = 1'b0;
        #1 early = hbus_out;
        repeat (2) @(negedge clk);
        hsel_n = 1'b1; hrd_n = 1'b1;
        @(negedge clk);
        while (hack_n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] v);
        bit seen;
        int n;
        @(negedge clk);
        hbus_in = v; hsel_n = 1'b0; hwr_n = 1'b0;
        seen = 0; n = 0;
        while (n < 2000) begin
            @(negedge clk);
            n++;
            if (hack_n) seen = 1;
            else if (seen) break;
        end
        hsel_n = 1'b1; hwr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] d, early;
        logic        oe;
        int          lat1, lat2, r0;
        logic [23:0] w;

        repeat (5) @(negedge clk);
        // R12 reset state
        check(hack_n == 1'b0, "R12 ack", 32'(hack_n), 0);
        check(ctl_addr_o == 0 && ctl_pm_o == 0, "R12 ctl", {ctl_pm_o, ctl_addr_o}, 0);
        check(mem_req == 1'b0, "R12 req", 32'(mem_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 data-memory latch and R3 sequential reads
        do_latch(1'b0, 3);
        check(ctl_addr_o == 3 && ctl_pm_o == 0, "R1 latch dm", {ctl_pm_o, ctl_addr_o}, 3);
        for (int k = 0; k < 6; k++) begin
            do_read(d, lat1, early, oe);
            check(d == dm_init(3 + k), "R3 dm read", d, dm_init(3 + k));
            check(oe == 1'b1, "R5 oe", 32'(oe), 1);
            check(ctl_addr_o == 14'(4 + k), "R3 addr step", ctl_addr_o, 4 + k);
            check(lat1 <= 5, "R6 dm latency", lat1, 5);
        end

        // R1 program-memory latch, R4 halves, R6 timing, R8 no fetch
        do_latch(1'b1, 8);
        check(ctl_addr_o == 8 && ctl_pm_o == 1, "R1 latch pm", {ctl_pm_o, ctl_addr_o}, 32'h4008);
        for (int k = 0; k < 4; k++) begin
            w = pm_init(8 + k);
            do_read(d, lat1, early, oe);
            check(d == w[23:8], "R4 first half", d, w[23:8]);
            check(ctl_addr_o == 14'(8 + k), "R4 addr hold", ctl_addr_o, 8 + k);
            check(lat1 <= 5, "R6 first latency", lat1, 5);
            r0 = nreq;
            do_read(d, lat2, early, oe);
            check(d == {8'h00, w[7:0]}, "R4 second half", d, {8'h00, w[7:0]});
            check(lat2 == lat1 - 1, "R6 second shorter", lat2, lat1 - 1);
            check(nreq == r0, "R8 no fetch", nreq, r0);
            check(ctl_addr_o == 14'(9 + k), "R4 addr step", ctl_addr_o, 9 + k);
        end

        // R11 data-memory writes, R3 readback
        do_latch(1'b0, 16);
        for (int k = 0; k < 4; k++) begin
            r0 = nreq;
            do_write(16'hC000 + 16'(k) * 16'h1111);
            check(nreq == r0 + 1, "R11 dm write per transfer", nreq, r0 + 1);
        end
        do_latch(1'b0, 16);
        for (int k = 0; k < 4; k++) begin
            do_read(d, lat1, early, oe);
            check(d == 16'hC000 + 16'(k) * 16'h1111, "R3 dm readback", d,
                  16'hC000 + 16'(k) * 16'h1111);
        end

        // R11 program-memory paired writes, upper byte ignored
        do_latch(1'b1, 24);
        for (int k = 0; k < 3; k++) begin
            w = 24'h5A0000 + 24'(k) * 24'h010203;
            r0 = nreq;
            do_write(w[23:8]);
            check(nreq == r0, "R11 pm no write on first half", nreq, r0);
            do_write({8'hFF, w[7:0]});
            check(nreq == r0 + 1, "R11 pm single write", nreq, r0 + 1);
            check(ctl_addr_o == 14'(25 + k), "R4 pm write addr", ctl_addr_o, 25 + k);
        end
        do_latch(1'b1, 24);
        for (int k = 0; k < 3; k++) begin
            w = 24'h5A0000 + 24'(k) * 24'h010203;
            do_read(d, lat1, early, oe);
            check(d == w[23:8], "R11 pm readback hi", d, w[23:8]);
            do_read(d, lat1, early, oe);
            check(d == {8'h00, w[7:0]}, "R11 pm readback lo", d, {8'h00, w[7:0]});
        end

        // R9 re-latch drops pending half
        do_latch(1'b1, 32);
        do_read(d, lat1, early, oe);
        do_latch(1'b1, 40);
        r0 = nreq;
        do_read(d, lat1, early, oe);
        w = pm_init(40);
        check(d == w[23:8], "R9 relatch first half", d, w[23:8]);
        check(nreq == r0 + 1, "R9 relatch fetch", nreq, r0 + 1);

        // R2 core control write, R9 drop by core write
        @(negedge clk);
        core_ctl_wdata = {1'b1, 14'd44};
        core_ctl_we = 1'b1;
        @(negedge clk);
        core_ctl_we = 1'b0;
        check(ctl_addr_o == 44 && ctl_pm_o == 1, "R2 core write", {ctl_pm_o, ctl_addr_o}, 32'h402C);
        r0 = nreq;
        do_read(d, lat1, early, oe);
        w = pm_init(44);
        check(d == w[23:8], "R9 core write first half", d, w[23:8]);
        check(nreq == r0 + 1, "R9 core write fetch", nreq, r0 + 1);

        // R10 short reads return previous word
        do_latch(1'b0, 48);
        short_read(early);
        check(early == w[23:8], "R10 dummy previous", early, w[23:8]);
        short_read(early);
        check(early == dm_init(48), "R10 short 48", early, dm_init(48));
        short_read(early);
        check(early == dm_init(49), "R10 short 49", early, dm_init(49));
        check(ctl_addr_o == 51, "R10 addr", ctl_addr_o, 51);

        // R7 grant gating
        do_latch(1'b0, 5);
        bnd_mode = 2;
        repeat (2) @(negedge clk);
        r0 = nreq;
        hsel_n = 1'b0; hrd_n = 1'b0;
        repeat (10) @(negedge clk);
        check(hack_n == 1'b1, "R7 wait for boundary", 32'(hack_n), 1);
        check(nreq == r0, "R7 no req without grant", nreq, r0);
        bnd_mode = 0;
        while (hack_n) @(negedge clk);
        check(hbus_out == dm_init(5), "R7 completes after grant", hbus_out, dm_init(5));
        hsel_n = 1'b1; hrd_n = 1'b1;
        repeat (3) @(negedge clk);
        bnd_mode = 1;
        for (int k = 0; k < 6; k++) begin
            do_read(d, lat1, early, oe);
            check(d == dm_init(6 + k), "R7 sparse boundary read", d, dm_init(6 + k));
        end
        bnd_mode = 0;
        summary();
    end

endmodule